// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Port

This block is the serial front end of a two-channel wiper controller. While the active-low chip select is held low, it shifts a 24-bit command word in from the serial data input, one bit per rising clock edge, most significant bit first. The word acts only when chip select returns high. If exactly 24 bits were clocked in, the block raises a one-cycle command strobe and presents the opcode, channel address and data field to the register controller beside it. Any other bit count discards the word.

The serial output lets several ports sit in one chain. In normal operation it replays the input stream 24 clocks late, so the bits shifted in during one frame come out during the next frame or during the tail of a longer frame. Two opcodes, 9 and 10, are readback requests. When one of them executes, the block replaces the chain contents with the opcode, the address and the requested channel value, and shifts that word out during the following frame. The output changes on falling clock edges. Its enable is high only while chip select is low. The open-drain pad is modelled as that data/enable pair.

Top module: `wiper_cmd_port`

## Requirements
- R1: A word of exactly 24 bits, followed by chip select rising, produces `cmdValid` high for exactly one clock cycle, starting at the first rising edge that samples chip select high. `cmdCode` is then word bits 23:20, `cmdAddr` is bits 19:16 and `cmdData` is bits 15:0, where bit 23 is the first bit shifted in.
- R2: `cmdValid` stays low for as long as chip select is low.
- R3: If chip select rises after any bit count other than 24 (for example 5, 23, 25 or 48), no command is issued.
- R4: Unless a readback has loaded new contents, the value on `sdo` sampled at rising edge k of a frame equals the serial input bit taken 24 rising edges earlier, counted only over edges with chip select low.
- R5: When opcode 9 (stored value) or opcode 10 (live value) executes, the next 24 bits on `sdo` are the opcode, then the address, then the 16-bit value, MSB first. The value is bits [16*a+15:16*a] of `storedVals` (opcode 9) or of `liveVals` (opcode 10) for address a of 0 or 1, and zero for any other address. Other opcodes leave the chain contents alone.
- R6: `sdoEn` is high while chip select is low and low while it is high, and `sdo` changes only on falling clock edges.
- R7: After reset, `cmdValid` is low, `sdo` is low, and the first 24 output bits of the first frame are all zero.
- R8: The bit counter clears while chip select is high, so a discarded short frame does not disturb the count of the full frame that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock. Input is sampled on its rising edge; output changes on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, MSB first |
| storedVals | input | NUM_CH*DATA_W | Stored value of each channel; channel a occupies slice a |
| liveVals | input | NUM_CH*DATA_W | Live value of each channel; channel a occupies slice a |
| sdo | output | 1 | Serial data out: delayed input stream or readback word |
| sdoEn | output | 1 | Output enable for `sdo` |
| cmdValid | output | 1 | One-cycle strobe for an accepted command |
| cmdCode | output | CODE_W | Opcode of the accepted command |
| cmdAddr | output | ADDR_W | Channel address of the accepted command |
| cmdData | output | DATA_W | Data field of the accepted command |

## Verification
A corrupted bit counter shows up as soon as the frame closes: a 24-bit word is dropped, or a word of the wrong length is accepted, and either one is seen on `cmdValid` one clock after chip select rises. A slip in the shift register, or a wrong readback selection, does not show in the frame that caused it. It appears on `sdo` during the next frame, so the checks compare every output bit of every frame against a running model of the chain contents. A missed chip-select edge shows either as a stuck or doubled strobe, or as decoded fields that do not match the word just sent.

// File: rtl/wcp_pkg.sv
`timescale 1ns/1ps
package wcp_pkg;
  // strobes from the frame control to the shift datapath
  typedef struct packed {
    logic shiftEn;   // chip select low: take one serial bit
    logic issue;     // full-length frame closed: publish the command
    logic loadRead;  // readback opcode closed: reload the chain register
  } wcpStrobe_t;
endpackage

// File: rtl/wcp_ctrl.sv
`timescale 1ns/1ps
module wcp_ctrl
  import wcp_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] RD_STORED = 4'd9,
  parameter logic [CODE_W-1:0] RD_LIVE = 4'd10,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [CODE_W-1:0] frameOp,
  output wcpStrobe_t        strobe,
  output logic [CNT_W-1:0]  bitCnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic csPrev;
  logic frameEnd;

  always_comb begin
    frameEnd        = csN && !csPrev;
    strobe.shiftEn  = !csN;
    strobe.issue    = frameEnd && (bitCnt == CNT_FULL);
    strobe.loadRead = strobe.issue && (frameOp == RD_STORED || frameOp == RD_LIVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      bitCnt <= '0;
    end else begin
      csPrev <= csN;
      if (csN)
        bitCnt <= '0;
      else if (bitCnt != CNT_SAT)
        bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/wcp_data.sv
`timescale 1ns/1ps
module wcp_data
  import wcp_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2,
  parameter logic [CODE_W-1:0] RD_LIVE = 4'd10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdi,
  input  wcpStrobe_t               strobe,
  input  logic [NUM_CH*DATA_W-1:0] storedVals,
  input  logic [NUM_CH*DATA_W-1:0] liveVals,
  output logic [CODE_W-1:0]        frameOp,
  output logic                     sdo,
  output logic                     cmdValid,
  output logic [CODE_W-1:0]        cmdCode,
  output logic [ADDR_W-1:0]        cmdAddr,
  output logic [DATA_W-1:0]        cmdData
);
  logic [WORD_W-1:0] chainReg;
  logic [ADDR_W-1:0] frameAddr;
  logic [DATA_W-1:0] frameData;
  logic [DATA_W-1:0] rbVal;
  logic [DATA_W-1:0] storedCh [NUM_CH];
  logic [DATA_W-1:0] liveCh   [NUM_CH];

  assign frameOp   = chainReg[WORD_W-1 -: CODE_W];
  assign frameAddr = chainReg[WORD_W-CODE_W-1 -: ADDR_W];
  assign frameData = chainReg[DATA_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign storedCh[g] = storedVals[g*DATA_W +: DATA_W];
    assign liveCh[g]   = liveVals[g*DATA_W +: DATA_W];
  end

  always_comb begin
    rbVal = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (frameAddr == ADDR_W'(i))
        rbVal = (frameOp == RD_LIVE) ? liveCh[i] : storedCh[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainReg <= '0;
      cmdValid <= 1'b0;
      cmdCode  <= '0;
      cmdAddr  <= '0;
      cmdData  <= '0;
    end else begin
      cmdValid <= strobe.issue;
      if (strobe.issue) begin
        cmdCode <= frameOp;
        cmdAddr <= frameAddr;
        cmdData <= frameData;
      end
      if (strobe.loadRead)
        chainReg <= {frameOp, frameAddr, rbVal};
      else if (strobe.shiftEn)
        chainReg <= {chainReg[WORD_W-2:0], sdi};
    end
  end

  // output launched half a cycle ahead of the downstream sampling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) sdo <= 1'b0;
    else       sdo <= chainReg[WORD_W-1];
  end
endmodule

// File: rtl/wiper_cmd_port.sv
`timescale 1ns/1ps
module wiper_cmd_port
  import wcp_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2,
  parameter logic [CODE_W-1:0] RD_STORED_OP = 4'd9,
  parameter logic [CODE_W-1:0] RD_LIVE_OP = 4'd10,
  localparam int WORD_W = CODE_W + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sdi,
  input  logic [NUM_CH*DATA_W-1:0] storedVals,
  input  logic [NUM_CH*DATA_W-1:0] liveVals,
  output logic                     sdo,
  output logic                     sdoEn,
  output logic                     cmdValid,
  output logic [CODE_W-1:0]        cmdCode,
  output logic [ADDR_W-1:0]        cmdAddr,
  output logic [DATA_W-1:0]        cmdData
);
  wcpStrobe_t        strobe;
  logic [CODE_W-1:0] frameOp;
  logic [CNT_W-1:0]  bitCnt;

  assign sdoEn = !csN;

  wcp_ctrl #(
    .WORD_W(WORD_W), .CODE_W(CODE_W),
    .RD_STORED(RD_STORED_OP), .RD_LIVE(RD_LIVE_OP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .frameOp(frameOp),
    .strobe(strobe), .bitCnt(bitCnt)
  );

  wcp_data #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .RD_LIVE(RD_LIVE_OP)
  ) u_data (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strobe(strobe),
    .storedVals(storedVals), .liveVals(liveVals), .frameOp(frameOp),
    .sdo(sdo), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData)
  );
endmodule

// File: rtl/wcp_checker.sv
`timescale 1ns/1ps
module wcp_checker #(
  parameter int WORD_W = 24,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] RD_STORED = 4'd9,
  parameter logic [CODE_W-1:0] RD_LIVE = 4'd10,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              cmdValid,
  input logic [CODE_W-1:0] cmdCode,
  input logic [CODE_W-1:0] frameOp,
  input logic [CNT_W-1:0]  bitCnt
);
  // R1: the command strobe lasts a single cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R2: a command only follows a clock edge that saw chip select high
  a_r2_exec_on_release: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(csN));

  // R3: an accepted frame had exactly the full word length
  a_r3_full_length: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(bitCnt) == CNT_W'(WORD_W)));

  // R8: the counter is clear after chip select has been high for an edge
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> (bitCnt == '0));

  // R5: a readback reloads the chain register starting with its opcode
  a_r5_readback_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == RD_STORED || cmdCode == RD_LIVE)) |-> (frameOp == cmdCode));
endmodule

bind wiper_cmd_port wcp_checker #(
  .WORD_W(WORD_W), .CODE_W(CODE_W),
  .RD_STORED(RD_STORED_OP), .RD_LIVE(RD_LIVE_OP)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .frameOp(frameOp), .bitCnt(bitCnt)
);

// File: tb/test_wiper_cmd_port.sv
`timescale 1ns/1ps
module test_wiper_cmd_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic [31:0] storedVals = 32'h19B6_D05A;
  logic [31:0] liveVals   = 32'h7E21_4C93;
  logic sdo, sdoEn, cmdValid;
  logic [3:0] cmdCode, cmdAddr;
  logic [15:0] cmdData;

  int nRun = 0;
  int nFail = 0;
  logic [23:0] model = '0;

  wiper_cmd_port i_wiper_cmd_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sdi(sdi),
    .storedVals(storedVals), .liveVals(liveVals),
    .sdo(sdo), .sdoEn(sdoEn), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rbExpect(input logic [3:0] op, input logic [3:0] addr);
    logic [31:0] src;
    src = (op == 4'd10) ? liveVals : storedVals;
    if (addr >= 4'd2) return 16'h0;
    return src[addr*16 +: 16];
  endfunction

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  // one frame of nbits bits; the word is repeated when nbits exceeds 24
  task automatic runFrame(input logic [23:0] word, input int nbits);
    int sdoErr = 0;
    int enErr = 0;
    int midValid = 0;
    bit expValid;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = word[23 - (i % 24)];
      csN = 1'b0;
      sdi = b;
      #1.4;
      if (sdo !== model[23]) sdoErr++;
      if (sdoEn !== 1'b1) enErr++;
      if (cmdValid !== 1'b0) midValid++;
      model = {model[22:0], b};
      nextCycle();
    end
    check(sdoErr == 0, "R4", "sdo bit mismatches in frame", sdoErr, 0);
    check(enErr == 0, "R6", "sdoEn low during frame", enErr, 0);
    check(midValid == 0, "R2", "cmdValid during frame", midValid, 0);
    csN = 1'b1;
    sdi = 1'b0;
    nextCycle();
    expValid = (nbits == 24);
    check(sdoEn == 1'b0, "R6", "sdoEn after release", sdoEn, 0);
    check(cmdValid == expValid, expValid ? "R1" : "R3", "cmdValid after release",
          cmdValid, expValid);
    if (expValid) begin
      check({cmdCode, cmdAddr, cmdData} == word, "R1", "decoded fields",
            {cmdCode, cmdAddr, cmdData}, word);
      if (word[23:20] == 4'd9 || word[23:20] == 4'd10)
        model = {word[23:20], word[19:16], rbExpect(word[23:20], word[19:16])};
    end
    nextCycle();
    check(cmdValid == 1'b0, "R1", "cmdValid one cycle only", cmdValid, 0);
  endtask

  initial begin
    #200000;
    nFail++;
    nRun++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #9;
    check(cmdValid == 1'b0, "R7", "cmdValid in reset", cmdValid, 0);
    check(sdo == 1'b0, "R7", "sdo in reset", sdo, 0);
    check(sdoEn == 1'b0, "R6", "sdoEn idle", sdoEn, 0);
    @(negedge clk);
    #0.5;
    rstN = 1'b1;
    nextCycle();
    nextCycle();
    // R7: first frame comes out as zeros; R8: short frame then full frame
    runFrame(24'h5A3C91, 5);
    runFrame(24'h3C_1234, 24);
    // sweep of every opcode against four addresses
    for (int op = 0; op < 16; op++) begin
      for (int ad = 0; ad < 4; ad++) begin
        logic [15:0] d;
        d = 16'(op * 4099 + ad * 611 + 77);
        runFrame({4'(op), 4'(ad), d}, 24);
      end
      if (op == 5)  runFrame(24'hA1_0F0F, 23);
      if (op == 9)  runFrame(24'h92_7777, 25);
      if (op == 12) runFrame(24'hA0_BEEF, 48);
    end
    // readback followed by a discarded long frame that shifts it out
    runFrame(24'h91_0000, 24);
    runFrame(24'h00_0000, 48);
    runFrame(24'h10_CAFE, 24);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule